// File: doc/BRIEF.md
# Dual Flash Lane Router

This block sits between a quad-lane serial flash transfer engine and one or two flash devices that the engine treats as one target with one logical select. A configuration word picks one of three routings. Single routing drives one device. Stacked routing puts both devices on one shared set of data and clock lines and picks the device by a page bit. Parallel routing gives each device its own four data lines and clock. Each engine byte is split bit by bit across the two devices, and read data is merged back into a byte. The second device's select is made inside the block.

The data lanes pass straight through and combine with the engine's clock and select in the same cycle, with no registers. There is no valid/ready handshake and no back-pressure: one lane word moves on every serial clock edge the engine makes, and the engine keeps the pace. The configuration register and the routing state it feeds are the only storage. The routing state takes a new configuration only while the logical select is deasserted, so a transfer in progress never changes devices. The engine's byte address is also translated for parallel routing, where each device holds half of every word.

Top module: `dflash_lane_router`

## Requirements
- R1: After reset the routing is single. The upper select `up_cs_n` is high, `up_sclk` is low, `up_io_oe` is low and `up_io_o` is zero.
- R2: A configuration write (`cfg_wr` high at a clock edge) stores three bits of `cfg_wdata`: bit 30 enables two devices, bit 29 enables separate buses, bit 28 selects the upper page. All other bits have no effect. When bit 30 is clear the routing is single, whatever bits 29 and 28 hold.
- R3: In single routing, `lo_cs_n` equals `eng_cs_n`, `lo_sclk` equals `eng_sclk`, `lo_io_o` equals `eng_wr[3:0]` and `eng_rd` equals `{4'b0, lo_io_i}`. The upper bus stays idle: select high, clock low, enable low, data zero.
- R4: In stacked routing (bit 30 set, bit 29 clear), a clear page bit routes `eng_cs_n` to `lo_cs_n` and holds `up_cs_n` high. A set page bit routes `eng_cs_n` to `up_cs_n` and holds `lo_cs_n` high. The two selects are never low together.
- R5: In stacked routing, both devices share the lower bus. `lo_sclk` follows `eng_sclk`, `lo_io_o` is `eng_wr[3:0]` and `eng_rd` is `{4'b0, lo_io_i}`, whichever page is chosen. The upper bus pins stay idle.
- R6: In parallel routing (bits 30 and 29 set), `lo_cs_n` and `up_cs_n` both follow `eng_cs_n`, and `lo_sclk` and `up_sclk` both follow `eng_sclk`.
- R7: In parallel routing, `lo_io_o[3:0]` carries `eng_wr` bits 6,4,2,0 and `up_io_o[3:0]` carries bits 7,5,3,1. Lane k gets bit 2k on the lower bus and bit 2k+1 on the upper bus.
- R8: In parallel routing, `eng_rd` bit 2k is `lo_io_i[k]` and bit 2k+1 is `up_io_i[k]`. A byte written and then read back from the two devices is returned unchanged.
- R9: `lo_io_oe` follows `eng_oe` in every routing. `up_io_oe` follows `eng_oe` in parallel routing and is low otherwise.
- R10: The routing in effect is loaded from the stored configuration at every clock edge where `eng_cs_n` is high, and it is held while `eng_cs_n` is low. A configuration write made during a transfer takes effect only from the next select assertion.
- R11: In parallel routing, `dev_addr` is `eng_addr` shifted right by one and `addr_err` is `eng_addr[0]`. In the other routings, `dev_addr` equals `eng_addr` and `addr_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| eng_cs_n | input | 1 | Logical select from the engine, active low |
| eng_sclk | input | 1 | Serial clock from the engine |
| eng_oe | input | 1 | Engine drives the data lines when high |
| eng_wr | input | 8 | Write lane word from the engine |
| eng_rd | output | 8 | Read lane word to the engine |
| eng_addr | input | 24 | Logical byte address |
| dev_addr | output | 24 | Address to send to each device |
| addr_err | output | 1 | Odd address in parallel routing |
| lo_cs_n | output | 1 | Lower device select |
| lo_sclk | output | 1 | Lower bus clock |
| lo_io_o | output | 4 | Lower bus write data |
| lo_io_oe | output | 1 | Lower bus output enable |
| lo_io_i | input | 4 | Lower bus read data |
| up_cs_n | output | 1 | Upper device select |
| up_sclk | output | 1 | Upper bus clock |
| up_io_o | output | 4 | Upper bus write data |
| up_io_oe | output | 1 | Upper bus output enable |
| up_io_i | input | 4 | Upper bus read data |

## Verification
The bench goes after the bit order in parallel routing with random bytes and loopback round trips. A swapped or shifted lane would corrupt half of each byte. It writes the page bit in the middle of a stacked transfer and checks that the select does not move until the select has been released and asserted again; a design that latched the page at once would switch devices in the middle of a command. Configurations with separate buses but no second device, and words with stray bits set, are used to catch decoding that goes into parallel or stacked routing by mistake. Even and odd addresses check the halving and the error flag, which a design could apply in the wrong routing.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

  typedef enum logic [1:0] {
    ROUTE_SINGLE   = 2'd0,
    ROUTE_STACKED  = 2'd1,
    ROUTE_PARALLEL = 2'd2
  } route_mode_e;

  typedef struct packed {
    route_mode_e mode;
    logic        upper;
  } route_state_t;

  function automatic route_mode_e decode_route(input logic two_dev, input logic sep_bus);
    if (!two_dev)     return ROUTE_SINGLE;
    else if (sep_bus) return ROUTE_PARALLEL;
    else              return ROUTE_STACKED;
  endfunction

endpackage

// File: rtl/dfr_cfg.sv
module dfr_cfg
  import dfr_pkg::*;
#(
  parameter int CFG_W    = 32,
  parameter int TWO_BIT  = 30,
  parameter int SEP_BIT  = 29,
  parameter int PAGE_BIT = 28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               eng_cs_n,
  output route_state_t       state
);

  logic         two_q, sep_q, page_q;
  route_state_t staged;

  // Stored configuration: only the three routing bits are kept.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      two_q  <= 1'b0;
      sep_q  <= 1'b0;
      page_q <= 1'b0;
    end else if (cfg_wr) begin
      two_q  <= cfg_wdata[TWO_BIT];
      sep_q  <= cfg_wdata[SEP_BIT];
      page_q <= cfg_wdata[PAGE_BIT];
    end
  end

  always_comb begin
    staged.mode  = decode_route(two_q, sep_q);
    staged.upper = page_q;
  end

  // Routing in effect is reloaded only between transfers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state <= '{mode: ROUTE_SINGLE, upper: 1'b0};
    else if (eng_cs_n) state <= staged;
  end

  a_r10_hold_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_cs_n && $past(!eng_cs_n)) |-> $stable(state));

endmodule

// File: rtl/dfr_sel.sv
module dfr_sel
  import dfr_pkg::*;
(
  input  route_state_t state,
  input  logic         eng_cs_n,
  input  logic         eng_sclk,
  output logic         lo_cs_n,
  output logic         up_cs_n,
  output logic         lo_sclk,
  output logic         up_sclk
);

  always_comb begin
    lo_cs_n = eng_cs_n;
    up_cs_n = 1'b1;
    lo_sclk = eng_sclk;
    up_sclk = 1'b0;
    unique case (state.mode)
      ROUTE_STACKED: begin
        lo_cs_n = state.upper ? 1'b1 : eng_cs_n;
        up_cs_n = state.upper ? eng_cs_n : 1'b1;
      end
      ROUTE_PARALLEL: begin
        up_cs_n = eng_cs_n;
        up_sclk = eng_sclk;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dfr_wr_split.sv
module dfr_wr_split
  import dfr_pkg::*;
#(
  parameter int LANES = 4,
  localparam int WORD_W = 2 * LANES
) (
  input  route_mode_e        mode,
  input  logic [WORD_W-1:0]  eng_wr,
  input  logic               eng_oe,
  output logic [LANES-1:0]   lo_io_o,
  output logic [LANES-1:0]   up_io_o,
  output logic               lo_io_oe,
  output logic               up_io_oe
);

  logic [LANES-1:0] even_bits, odd_bits;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign even_bits[k] = eng_wr[2*k];
    assign odd_bits[k]  = eng_wr[2*k+1];
  end

  always_comb begin
    lo_io_oe = eng_oe;
    if (mode == ROUTE_PARALLEL) begin
      lo_io_o  = even_bits;
      up_io_o  = odd_bits;
      up_io_oe = eng_oe;
    end else begin
      lo_io_o  = eng_wr[LANES-1:0];
      up_io_o  = '0;
      up_io_oe = 1'b0;
    end
  end

endmodule

// File: rtl/dfr_rd_merge.sv
module dfr_rd_merge
  import dfr_pkg::*;
#(
  parameter int LANES = 4,
  localparam int WORD_W = 2 * LANES
) (
  input  route_mode_e        mode,
  input  logic [LANES-1:0]   lo_io_i,
  input  logic [LANES-1:0]   up_io_i,
  output logic [WORD_W-1:0]  eng_rd
);

  logic [WORD_W-1:0] merged;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign merged[2*k]   = lo_io_i[k];
    assign merged[2*k+1] = up_io_i[k];
  end

  assign eng_rd = (mode == ROUTE_PARALLEL) ? merged : {{LANES{1'b0}}, lo_io_i};

endmodule

// File: rtl/dflash_lane_router.sv
module dflash_lane_router
  import dfr_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int ADDR_W   = 24,
  parameter int CFG_W    = 32,
  parameter int TWO_BIT  = 30,
  parameter int SEP_BIT  = 29,
  parameter int PAGE_BIT = 28,
  localparam int WORD_W  = 2 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              eng_cs_n,
  input  logic              eng_sclk,
  input  logic              eng_oe,
  input  logic [WORD_W-1:0] eng_wr,
  output logic [WORD_W-1:0] eng_rd,
  input  logic [ADDR_W-1:0] eng_addr,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              addr_err,
  output logic              lo_cs_n,
  output logic              lo_sclk,
  output logic [LANES-1:0]  lo_io_o,
  output logic              lo_io_oe,
  input  logic [LANES-1:0]  lo_io_i,
  output logic              up_cs_n,
  output logic              up_sclk,
  output logic [LANES-1:0]  up_io_o,
  output logic              up_io_oe,
  input  logic [LANES-1:0]  up_io_i
);

  route_state_t state;
  logic         par;

  dfr_cfg #(
    .CFG_W(CFG_W), .TWO_BIT(TWO_BIT), .SEP_BIT(SEP_BIT), .PAGE_BIT(PAGE_BIT)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .eng_cs_n(eng_cs_n), .state(state)
  );

  dfr_sel u_sel (
    .state(state), .eng_cs_n(eng_cs_n), .eng_sclk(eng_sclk),
    .lo_cs_n(lo_cs_n), .up_cs_n(up_cs_n), .lo_sclk(lo_sclk), .up_sclk(up_sclk)
  );

  dfr_wr_split #(.LANES(LANES)) u_wr (
    .mode(state.mode), .eng_wr(eng_wr), .eng_oe(eng_oe),
    .lo_io_o(lo_io_o), .up_io_o(up_io_o), .lo_io_oe(lo_io_oe), .up_io_oe(up_io_oe)
  );

  dfr_rd_merge #(.LANES(LANES)) u_rd (
    .mode(state.mode), .lo_io_i(lo_io_i), .up_io_i(up_io_i), .eng_rd(eng_rd)
  );

  // Each device holds half of every word in parallel routing.
  assign par      = (state.mode == ROUTE_PARALLEL);
  assign dev_addr = par ? {1'b0, eng_addr[ADDR_W-1:1]} : eng_addr;
  assign addr_err = par & eng_addr[0];

  a_r4_never_both_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (state.mode == ROUTE_STACKED) |-> (lo_cs_n || up_cs_n));

  a_r3_upper_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state.mode == ROUTE_SINGLE) |-> (up_cs_n && !up_sclk && !up_io_oe && up_io_o == '0));

  a_r6_selects_together: assert property (@(posedge clk) disable iff (!rst_n)
    par |-> (lo_cs_n == up_cs_n && lo_sclk == up_sclk));

  a_r8_loopback_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (par && lo_io_i == lo_io_o && up_io_i == up_io_o) |-> (eng_rd == eng_wr));

  a_r11_odd_address_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (par && eng_addr[0]) |-> addr_err);

endmodule

// File: tb/dflash_lane_router_test.sv
module dflash_lane_router_test;

  localparam int OBS_W = 47;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        eng_cs_n = 1'b1;
  logic        eng_sclk = 1'b0;
  logic        eng_oe = 1'b0;
  logic [7:0]  eng_wr = '0;
  logic [7:0]  eng_rd;
  logic [23:0] eng_addr = '0;
  logic [23:0] dev_addr;
  logic        addr_err;
  logic        lo_cs_n, lo_sclk, lo_io_oe, up_cs_n, up_sclk, up_io_oe;
  logic [3:0]  lo_io_o, up_io_o;
  logic [3:0]  lo_io_i = '0;
  logic [3:0]  up_io_i = '0;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [OBS_W-1:0] exp_q[$];
  string            tag_q[$];

  // Bench view of the routing: {two, sep, page}
  logic [2:0] bcfg, beff;

  always #10 clk = ~clk;

  dflash_lane_router uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .eng_cs_n(eng_cs_n), .eng_sclk(eng_sclk), .eng_oe(eng_oe),
    .eng_wr(eng_wr), .eng_rd(eng_rd), .eng_addr(eng_addr),
    .dev_addr(dev_addr), .addr_err(addr_err),
    .lo_cs_n(lo_cs_n), .lo_sclk(lo_sclk), .lo_io_o(lo_io_o),
    .lo_io_oe(lo_io_oe), .lo_io_i(lo_io_i),
    .up_cs_n(up_cs_n), .up_sclk(up_sclk), .up_io_o(up_io_o),
    .up_io_oe(up_io_oe), .up_io_i(up_io_i)
  );

  // R2 / R10 model: stored bits on a write, effective copy while select is high
  always @(posedge clk) begin
    if (!rst_n) begin
      bcfg <= 3'b000;
      beff <= 3'b000;
    end else begin
      if (cfg_wr) bcfg <= {cfg_wdata[30], cfg_wdata[29], cfg_wdata[28]};
      if (eng_cs_n) beff <= bcfg;
    end
  end

  function automatic logic [3:0] even_of(input logic [7:0] b);
    for (int k = 0; k < 4; k++) even_of[k] = b[2*k];
  endfunction

  function automatic logic [3:0] odd_of(input logic [7:0] b);
    for (int k = 0; k < 4; k++) odd_of[k] = b[2*k+1];
  endfunction

  function automatic logic [7:0] join_of(input logic [3:0] lo, input logic [3:0] up);
    for (int k = 0; k < 4; k++) begin
      join_of[2*k]   = lo[k];
      join_of[2*k+1] = up[k];
    end
  endfunction

  function automatic logic [OBS_W-1:0] reference(input logic [2:0] eff);
    logic par, stk, page;
    logic e_lcs, e_ucs, e_ucl, e_uoe, e_err;
    logic [3:0] e_lo, e_up;
    logic [7:0] e_rd;
    logic [23:0] e_addr;
    par = eff[2] & eff[1];
    stk = eff[2] & ~eff[1];
    page = eff[0];
    e_lcs = (stk && page) ? 1'b1 : eng_cs_n;
    e_ucs = par ? eng_cs_n : ((stk && page) ? eng_cs_n : 1'b1);
    e_ucl = par ? eng_sclk : 1'b0;
    e_uoe = par ? eng_oe : 1'b0;
    e_lo  = par ? even_of(eng_wr) : eng_wr[3:0];
    e_up  = par ? odd_of(eng_wr) : 4'h0;
    e_rd  = par ? join_of(lo_io_i, up_io_i) : {4'h0, lo_io_i};
    e_addr = par ? (eng_addr >> 1) : eng_addr;
    e_err = par & eng_addr[0];
    return {e_lcs, e_ucs, eng_sclk, e_ucl, eng_oe, e_uoe, e_lo, e_up, e_rd, e_addr, e_err};
  endfunction

  // Driver: apply one lane cycle and queue what the outputs must be
  task automatic drive(input string tag, input logic cs, input logic [7:0] wr,
                       input logic [3:0] li, input logic [3:0] ui, input logic [23:0] a);
    @(posedge clk);
    #1;
    eng_cs_n = cs;
    eng_sclk = $urandom_range(0, 1);
    eng_oe   = $urandom_range(0, 1);
    eng_wr   = wr;
    lo_io_i  = li;
    up_io_i  = ui;
    eng_addr = a;
    #1;
    exp_q.push_back(reference(beff));
    tag_q.push_back(tag);
  endtask

  task automatic drive_rand(input string tag, input logic cs);
    drive(tag, cs, 8'($urandom), 4'($urandom), 4'($urandom), 24'($urandom));
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(posedge clk);
    #1;
    cfg_wr = 1'b1;
    cfg_wdata = w;
    @(posedge clk);
    #1;
    cfg_wr = 1'b0;
  endtask

  // Idle cycles with the select released so the new routing loads
  task automatic settle();
    drive_rand("R10", 1'b1);
    drive_rand("R10", 1'b1);
  endtask

  // Monitor: pop and compare between clock edges
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [OBS_W-1:0] act, exp;
      string t;
      exp = exp_q.pop_front();
      t   = tag_q.pop_front();
      act = {lo_cs_n, up_cs_n, lo_sclk, up_sclk, lo_io_oe, up_io_oe,
             lo_io_o, up_io_o, eng_rd, dev_addr, addr_err};
      compared++;
      if (act !== exp) begin
        mismatched++;
        $display("FAIL %s: actual %h expected %h", t, act, exp);
      end
    end
  end

  initial begin
    #3000000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state is single routing
    drive_rand("R1", 1'b1);
    drive_rand("R1", 1'b0);

    // R3: single routing with random traffic
    for (int i = 0; i < 12; i++) drive_rand("R3", i[0]);

    // R2: separate-bus and page bits without bit 30 stay single
    write_cfg(32'hBFFF_FFFF);
    settle();
    for (int i = 0; i < 6; i++) drive_rand("R2", i[1]);

    // R4 / R5: stacked, lower page
    write_cfg(32'h4000_0000);
    settle();
    for (int i = 0; i < 8; i++) drive_rand("R4", i[0]);
    // R4 / R5: stacked, upper page (stray bits must not matter, R2)
    write_cfg(32'h5000_00A5);
    settle();
    for (int i = 0; i < 8; i++) drive_rand("R5", i[0]);

    // R10: page written mid-transfer takes effect at the next assertion
    write_cfg(32'h4000_0000);
    settle();
    drive_rand("R10", 1'b0);
    write_cfg(32'h5000_0000);
    for (int i = 0; i < 4; i++) drive_rand("R10", 1'b0);
    drive_rand("R10", 1'b1);
    for (int i = 0; i < 3; i++) drive_rand("R10", 1'b0);

    // R6 / R7 / R9: parallel routing with random bytes
    write_cfg(32'h6000_0000);
    settle();
    for (int i = 0; i < 16; i++) drive_rand("R7", i[0]);

    // R8: write-then-read round trips through the two devices
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      drive("R8", 1'b0, b, 4'($urandom), 4'($urandom), 24'd0);
      drive("R8", 1'b0, 8'($urandom), even_of(b), odd_of(b), 24'd2);
    end
    drive("R8", 1'b0, 8'hFF, 4'hF, 4'h0, 24'd4);
    drive("R8", 1'b0, 8'h55, 4'h0, 4'hF, 24'd6);

    // R11: even and odd addresses in parallel, then back to single
    drive("R11", 1'b0, 8'h00, 4'h0, 4'h0, 24'h000100);
    drive("R11", 1'b0, 8'h00, 4'h0, 4'h0, 24'hFFFFFF);
    drive("R11", 1'b1, 8'h00, 4'h0, 4'h0, 24'h000001);
    write_cfg(32'h2000_0000);
    settle();
    drive("R11", 1'b0, 8'h00, 4'h0, 4'h0, 24'h000003);
    drive_rand("R9", 1'b0);

    while (exp_q.size() > 0) @(posedge clk);
    @(posedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule